// File: doc/BRIEF.md
# Quasi-resonant flyback cycle sequencer

This block times the switching cycles of a flyback converter that runs in quasi-resonant or variable-frequency mode. It drives a single gate-enable output from three digitised inputs. The first is a comparator flag that rises when the auxiliary winding rings up through its threshold, which marks a drain valley. The second is a flag that goes high when the primary current reaches its setpoint. The third is an 8-bit frequency-foldback code that comes from the error path. All inputs are synchronous to `clk`. The analog front end, the setpoint arithmetic and the driver stage sit outside this block.

A turn-on sets the gate. The gate is cleared by the first current trip that arrives after a leading-edge blanking window. After each turn-on, a period timer decides when a new cycle may be requested. Code 0 gives the shortest period, which is the maximum-frequency clamp. Larger codes lengthen the period linearly. The all-ones code stops switching. Once a request is pending, the next cycle starts on the first valley edge. If the ringing has died out, it starts on a ringing-loss timeout instead.

All timing is derived from the clock-frequency parameter, so a bench can scale it down. The default build gives a 200 ns blanking window, an 8 µs minimum period (125 kHz), a 4 µs ringing timeout and a foldback step of one thirty-second of the minimum period.

Top module: `qr_cycle_seq`

## Requirements
- R1: While reset is asserted and while `enable` is low, `gate_on` is 0. No cycle starts until a full period has elapsed after `enable` is first sampled high.
- R2: A valley edge is `demag_cmp` sampled 1 at a clock edge after being sampled 0 at the previous edge. When a request is pending and the gate is off, a valley edge sets `gate_on` at that same clock edge.
- R3: With `fold_code` = 0, the period P equals MIN clock cycles (`CLK_HZ/FMAX_HZ`). A request becomes pending P edges after the last turn-on edge, valley edges before that are ignored, and two rising edges of `gate_on` are never closer than MIN cycles.
- R4: A current trip sampled at edge r+k after a turn-on at edge r clears `gate_on` at that edge only when k >= BLANK (200 ns of clock). Trips at k < BLANK are ignored. The gate falls only on such a trip or on `enable` low.
- R5: For `fold_code` = c in 1..254, P = MIN + c*STEP with STEP = MIN/FOLD_DIV. Valley edges before P has elapsed are ignored, and the first valley edge at or after that point starts the cycle.
- R6: When a request is pending and TMO cycles (4 µs of clock) have passed since the later of the last valley edge and the last turn-on, a cycle starts with no valley edge.
- R7: While `fold_code` is 8'hFF, no cycle starts. When the code leaves 8'hFF after the period has run out, the request pends at the next edge and a cycle may start one edge later.
- R8: The first edge that samples `enable` low clears `gate_on` and the pending request, even inside the blanking window. It also restarts the period timer from that edge, as if a turn-on had occurred there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low forces the gate off |
| demag_cmp | input | 1 | Demagnetisation comparator flag, synchronous |
| ipk_cmp | input | 1 | Peak-current-reached flag, synchronous |
| fold_code | input | 8 | Foldback code: 0 maximum frequency, 255 stop |
| gate_on | output | 1 | Gate enable to the driver |

## Verification
The assertions assume that every input is already synchronous to `clk`. They allow the current trip and the valley flag to change at any edge, including while the gate is on. They also allow the foldback code to change at any time. The stimulus changes inputs only on the falling clock edge. It applies valley pulses three cycles wide with gaps shorter than the ringing timeout wherever a valley start must be told apart from a timeout start. Between scenarios it holds `enable` low for longer than the timeout, so every scenario begins from a known timer state.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef logic [7:0] fold_code_t;

  localparam fold_code_t FOLD_STOP = 8'hFF;
  localparam int         FOLD_MAX_RUN = 254;

  // clock cycles spanning a duration in nanoseconds
  function automatic int ns_to_cyc(input int clk_hz, input int ns);
    return ((clk_hz / 1000) * ns) / 1_000_000;
  endfunction

  // clock cycles in one period of a frequency
  function automatic int hz_to_cyc(input int clk_hz, input int f_hz);
    return clk_hz / f_hz;
  endfunction
endpackage

// File: rtl/qrs_ring_watch.sv
// Valley edge detection and ringing-loss timeout.
module qrs_ring_watch #(
  parameter int TMO_CYC = 1000,
  localparam int TW = $clog2(TMO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic demag_i,
  input  logic restart_i,
  output logic valley_o,
  output logic dead_o
);
  logic          dm_q;
  logic [TW-1:0] quiet_cnt;

  assign valley_o = demag_i & ~dm_q;
  assign dead_o   = (quiet_cnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q      <= 1'b0;
      quiet_cnt <= TW'(TMO_CYC - 1);
    end else begin
      dm_q <= demag_i;
      if (valley_o || restart_i)
        quiet_cnt <= '0;
      else if (!dead_o)
        quiet_cnt <= quiet_cnt + TW'(1);
    end
  end
endmodule

// File: rtl/qrs_period_timer.sv
// Period timer since the last turn-on: blanking window and latched cycle request.
module qrs_period_timer
  import qrs_pkg::*;
#(
  parameter int MIN_CYC   = 2000,
  parameter int STEP_CYC  = 62,
  parameter int BLANK_CYC = 50,
  parameter int CNT_W     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       start_i,
  input  fold_code_t code_i,
  output logic       blank_done_o,
  output logic       req_o
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] vco_per;
  logic             tick;

  assign vco_per      = CNT_W'(MIN_CYC) + CNT_W'(code_i) * CNT_W'(STEP_CYC);
  assign tick         = (code_i != FOLD_STOP) && (per_cnt >= vco_per - CNT_W'(2));
  assign blank_done_o = (per_cnt >= CNT_W'(BLANK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      req_o   <= 1'b0;
    end else begin
      if (!en_i || start_i)
        per_cnt <= '0;
      else if (per_cnt != SAT)
        per_cnt <= per_cnt + CNT_W'(1);

      if (!en_i || start_i)
        req_o <= 1'b0;
      else if (tick)
        req_o <= 1'b1;
    end
  end
endmodule

// File: rtl/qrs_gate_ctl.sv
// Gate flip-flop with start arbitration and blanked current trip.
module qrs_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic stop_i,
  input  logic req_i,
  input  logic valley_i,
  input  logic dead_i,
  input  logic blank_done_i,
  input  logic trip_i,
  output logic start_o,
  output logic gate_o
);
  logic trip_ok;

  assign start_o = en_i & ~stop_i & ~gate_o & req_i & (valley_i | dead_i);
  assign trip_ok = gate_o & trip_i & blank_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_o <= 1'b0;
    else if (!en_i)   gate_o <= 1'b0;
    else if (start_o) gate_o <= 1'b1;
    else if (trip_ok) gate_o <= 1'b0;
  end
endmodule

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq
  import qrs_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int FMAX_HZ     = 125_000,
  parameter int BLANK_NS    = 200,
  parameter int RING_TMO_NS = 4000,
  parameter int FOLD_DIV    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       demag_cmp,
  input  logic       ipk_cmp,
  input  logic [7:0] fold_code,
  output logic       gate_on
);
  localparam int MIN_CYC   = hz_to_cyc(CLK_HZ, FMAX_HZ);
  localparam int STEP_CYC  = MIN_CYC / FOLD_DIV;
  localparam int BLANK_CYC = ns_to_cyc(CLK_HZ, BLANK_NS);
  localparam int TMO_CYC   = ns_to_cyc(CLK_HZ, RING_TMO_NS);
  localparam int MAX_PER   = MIN_CYC + FOLD_MAX_RUN * STEP_CYC;
  localparam int CNT_W     = $clog2(MAX_PER + 1);

  logic start, valley, dead, blank_done, req;

  qrs_ring_watch #(.TMO_CYC(TMO_CYC)) u_ring (
    .clk(clk), .rst_n(rst_n), .demag_i(demag_cmp), .restart_i(start),
    .valley_o(valley), .dead_o(dead)
  );

  qrs_period_timer #(
    .MIN_CYC(MIN_CYC), .STEP_CYC(STEP_CYC), .BLANK_CYC(BLANK_CYC), .CNT_W(CNT_W)
  ) u_period (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .start_i(start), .code_i(fold_code),
    .blank_done_o(blank_done), .req_o(req)
  );

  qrs_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .stop_i(fold_code == FOLD_STOP),
    .req_i(req), .valley_i(valley), .dead_i(dead), .blank_done_i(blank_done),
    .trip_i(ipk_cmp), .start_o(start), .gate_o(gate_on)
  );
endmodule

// File: rtl/qrs_chk.sv
module qrs_chk #(
  parameter int MIN_CYC   = 2000,
  parameter int BLANK_CYC = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       ipk_cmp,
  input logic [7:0] fold_code,
  input logic       gate_on
);
  logic gate_q;
  int   since_rise;
  int   on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      since_rise <= MIN_CYC;
      on_cnt     <= 0;
    end else begin
      gate_q <= gate_on;
      if (gate_on && !gate_q)       since_rise <= 1;
      else if (since_rise < MIN_CYC) since_rise <= since_rise + 1;
      if (!gate_on)                 on_cnt <= 0;
      else if (on_cnt < BLANK_CYC)  on_cnt <= on_cnt + 1;
    end
  end

  assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !gate_q) |-> (since_rise >= MIN_CYC));

  assert_blanking_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !gate_on && $past(enable)) |-> (on_cnt >= BLANK_CYC));

  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !gate_on) |-> ($past(ipk_cmp) || !$past(enable)));

  assert_stop_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_code == 8'hFF && !gate_on) |=> !gate_on);

  assert_enable_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate_on);

  assert_rise_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !gate_q) |-> $past(enable));
endmodule

bind qr_cycle_seq qrs_chk #(.MIN_CYC(MIN_CYC), .BLANK_CYC(BLANK_CYC)) u_qrs_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ipk_cmp(ipk_cmp),
  .fold_code(fold_code), .gate_on(gate_on)
);

// File: tb/tb_qr_cycle_seq.sv
module tb_qr_cycle_seq;
  // scaled clock parameter: MIN=200, STEP=6, BLANK=5, TMO=100 cycles
  localparam int MIN   = 200;
  localparam int STEP  = 6;
  localparam int BLANK = 5;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, demag_cmp = 1'b0, ipk_cmp = 1'b0;
  logic [7:0] fold_code = 8'd0;
  logic gate_on;

  qr_cycle_seq #(.CLK_HZ(25_000_000)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .demag_cmp(demag_cmp),
    .ipk_cmp(ipk_cmp), .fold_code(fold_code), .gate_on(gate_on)
  );

  always #2 clk = ~clk;

  typedef struct { int cyc; bit lvl; string tag; } ev_t;
  ev_t   expq[$];
  int    cyc = 0, tests = 0, fails = 0;
  bit    mon_on = 1'b0, gate_prev = 1'b0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic expect_ev(input int c, input bit l, input string tag);
    ev_t e;
    e.cyc = c; e.lvl = l; e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor: pops expected gate transitions and compares them
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && gate_on !== gate_prev) begin
        if (expq.size() == 0) begin
          tests++; fails++;
          $display("FAIL %s: actual gate change to %0b at cycle %0d expected none",
                   cur_req, gate_on, cyc);
        end else begin
          ev_t e;
          e = expq.pop_front();
          tests++;
          if (e.cyc != cyc || e.lvl != gate_on) begin
            fails++;
            $display("FAIL %s: actual %0b at cycle %0d expected %0b at cycle %0d",
                     e.tag, gate_on, cyc, e.lvl, e.cyc);
          end
        end
        gate_prev = gate_on;
      end
    end
  end

  task automatic at_cyc(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic pulse(input int c);
    at_cyc(c); demag_cmp = 1'b1;
    at_cyc(c + 3); demag_cmp = 1'b0;
  endtask

  task automatic idle_off(input int n);
    enable = 1'b0;
    at_cyc(cyc + n);
  endtask

  task automatic drained(input string tag);
    chk(expq.size() == 0, tag, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    int m, r;
    repeat (5) @(negedge clk);
    chk(gate_on == 1'b0, "R1 gate in reset", gate_on, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle_off(300);
    chk(gate_on == 1'b0, "R1 gate with enable low", gate_on, 0);

    // timeout start and minimum period at code 0, trip held
    cur_req = "R3"; fold_code = 8'd0; ipk_cmp = 1'b1;
    m = cyc; enable = 1'b1; r = m + MIN;
    expect_ev(r, 1, "R6 timeout start after enable");
    expect_ev(r + BLANK, 0, "R4 trip right after blanking");
    expect_ev(r + MIN, 1, "R3 restart at minimum period");
    expect_ev(r + MIN + BLANK, 0, "R4 trip second cycle");
    at_cyc(r + MIN + 50);
    drained("R3 events seen");
    idle_off(300);

    // valley start in borderline mode; early valleys ignored
    cur_req = "R2";
    m = cyc; enable = 1'b1; r = m + MIN;
    expect_ev(r, 1, "R2 first cycle");
    expect_ev(r + BLANK, 0, "R4 first cycle trip");
    expect_ev(r + 211, 1, "R2 valley start after period");
    expect_ev(r + 216, 0, "R4 valley cycle trip");
    for (int k = 0; k < 5; k++) pulse(r + 50 + 40 * k);
    at_cyc(r + 260);
    drained("R2 events seen");
    idle_off(300);

    // foldback code 10: period 260, valley before it ignored, then timeout restart
    cur_req = "R5"; fold_code = 8'd10;
    m = cyc; enable = 1'b1; r = m + MIN + 10 * STEP;
    expect_ev(r, 1, "R5 first cycle");
    expect_ev(r + BLANK, 0, "R4 trip");
    expect_ev(r + 291, 1, "R5 first valley after folded period");
    expect_ev(r + 296, 0, "R4 trip");
    expect_ev(r + 291 + 260, 1, "R6 timeout restart at folded period");
    expect_ev(r + 556, 0, "R4 trip");
    for (int k = 0; k < 7; k++) pulse(r + 50 + 40 * k);
    at_cyc(r + 600);
    drained("R5 events seen");
    idle_off(300);

    // blanking boundary and enable kill while on
    cur_req = "R4"; fold_code = 8'd0; ipk_cmp = 1'b0;
    m = cyc; enable = 1'b1; r = m + MIN;
    expect_ev(r, 1, "R4 cycle start");
    expect_ev(r + BLANK, 0, "R4 trip at first unblanked edge");
    expect_ev(r + MIN, 1, "R4 next cycle");
    expect_ev(r + 251, 0, "R8 enable low clears gate");
    at_cyc(r + 1); ipk_cmp = 1'b1;
    at_cyc(r + 3); ipk_cmp = 1'b0;
    at_cyc(r + 4); ipk_cmp = 1'b1;
    at_cyc(r + 5); ipk_cmp = 1'b0;
    at_cyc(r + 250); enable = 1'b0;
    at_cyc(r + 260);
    drained("R4 events seen");
    ipk_cmp = 1'b1;
    idle_off(300);

    // stop code holds off switching; leaving it restarts
    cur_req = "R7"; fold_code = 8'hFF;
    m = cyc; enable = 1'b1;
    for (int k = 0; k < 6; k++) pulse(m + 50 + 40 * k);
    at_cyc(m + 399);
    chk(gate_on == 1'b0, "R7 no cycle under stop code", gate_on, 0);
    expect_ev(m + 402, 1, "R7 restart after leaving stop");
    expect_ev(m + 407, 0, "R4 trip");
    at_cyc(m + 400); fold_code = 8'd0;
    at_cyc(m + 450);
    drained("R7 events seen");
    idle_off(300);

    // enable dip clears a pending request and restarts the period
    cur_req = "R8"; fold_code = 8'd10;
    m = cyc; enable = 1'b1; r = m + MIN + 10 * STEP;
    expect_ev(r, 1, "R8 first cycle");
    expect_ev(r + BLANK, 0, "R4 trip");
    expect_ev(r + 571, 1, "R8 request cleared, next valley after new period");
    expect_ev(r + 576, 0, "R4 trip");
    for (int k = 0; k < 6; k++) pulse(r + 50 + 40 * k);
    at_cyc(r + 280); enable = 1'b0;
    at_cyc(r + 281); enable = 1'b1;
    for (int k = 6; k < 14; k++) pulse(r + 50 + 40 * k);
    at_cyc(r + 620);
    drained("R8 events seen");
    idle_off(20);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule